// File: doc/BRIEF.md
# Thermocouple Converter Serial Reader

This block is a receive-only serial master for a cold-junction-compensated thermocouple converter. A single-cycle `start_i` pulse asks for a reading. The block then drives chip select low and produces a divided serial clock. It captures one 16-bit frame from the converter's data line and decodes the frame into a 12-bit temperature code, an open-input flag, a validity flag and a protocol-error flag. A single-cycle `done_o` pulse marks the moment these results change.

Chip select stays high between reads. While it is high the converter runs its next conversion. The block therefore holds off any new read until a conversion-time counter (`CONV_WAIT` system clocks) has expired. A request that arrives during a read or during the hold-off is remembered, not lost. Several requests that arrive while one is already pending count as a single read.

Top module: `tc_serial_reader`

## Requirements
- R1: While reset is asserted, and after it is released with no start request, `cs_n_o` is 1, `sclk_o` is 0, and `done_o`, `valid_o`, `err_o`, `open_o` and `temp_o` are all 0.
- R2: The serial clock is low whenever chip select is high. After a start, chip select falls at least `HALF_DIV` system clocks before the first rising edge of `sclk_o`.
- R3: Each read has exactly 16 rising edges of `sclk_o` while `cs_n_o` is low. Chip select returns high together with the 16th falling edge.
- R4: A bit is captured from `sdo_i` at each falling edge of `sclk_o`. The first bit captured is frame bit 15. Frame bits 14 down to 3 form `temp_o[11:0]`, most significant bit first.
- R5: Frame bit 2 appears on `open_o`. When it is 1, `valid_o` is 0.
- R6: If frame bit 15 (the sign bit) is 1, `err_o` is 1 and `valid_o` is 0.
- R7: If frame bit 1 (the device-identity bit) is 1, `err_o` is 1 and `valid_o` is 0.
- R8: Frame bit 0 has no effect on any output.
- R9: `done_o` is high for exactly one cycle per read. `temp_o`, `open_o`, `err_o` and `valid_o` change only in that cycle and hold their values until the next `done_o`. `valid_o` is 1 exactly when the open, sign and identity bits are all 0.
- R10: After a read, chip select stays high for at least `CONV_WAIT` system clocks. A start request given during that time is served once the time has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Read request pulse |
| sdo_i | input | 1 | Serial data from converter |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| done_o | output | 1 | One-cycle pulse when a frame is decoded |
| temp_o | output | 12 | Temperature code of the last frame |
| open_o | output | 1 | Thermocouple input open in last frame |
| err_o | output | 1 | Sign or identity bit was nonzero in last frame |
| valid_o | output | 1 | Last frame is usable |

## Verification
The case that is hardest to reach from the ports is a request that arrives while the conversion hold-off is still running. In that case the block must keep chip select high for the whole wait and still launch the read afterwards. The bench reaches it by pulsing start in the cycle right after a done pulse. It then counts the cycles until chip select falls and checks that the deferred frame decodes correctly. A behavioural converter model on the bench side shifts out chosen frames. These frames drive each flag bit alone and flip only the undriven last bit, so each field of the decode is tested on its own.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2
  } tcr_state_e;

  typedef struct packed {
    logic [11:0] temp;
    logic        open_in;
    logic        err;
    logic        valid;
  } tcr_result_t;
endpackage

// File: rtl/tcr_clkdiv.sv
module tcr_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tcr_holdoff.sv
module tcr_holdoff #(
  parameter int CONV_WAIT = 22_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int HW = $clog2(CONV_WAIT + 1);
  localparam logic [HW-1:0] LOADV = HW'(CONV_WAIT);

  logic [HW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = LOADV;
    else if (!expired) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tcr_decode.sv
module tcr_decode
  import tcr_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int TEMP_W  = 12
) (
  input  logic [FRAME_W-1:0] frame,
  output tcr_result_t        res
);
  localparam int SIGN_POS = FRAME_W - 1;
  localparam int TEMP_HI  = FRAME_W - 2;
  localparam int OPEN_POS = 2;
  localparam int ID_POS   = 1;

  logic sign_bit, id_bit, open_bit;

  assign sign_bit = frame[SIGN_POS];
  assign id_bit   = frame[ID_POS];
  assign open_bit = frame[OPEN_POS];

  always_comb begin
    res.temp    = frame[TEMP_HI -: TEMP_W];
    res.open_in = open_bit;
    res.err     = sign_bit | id_bit;
    res.valid   = ~(sign_bit | id_bit | open_bit);
  end
endmodule

// File: rtl/tc_serial_reader.sv
module tc_serial_reader
  import tcr_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int CONV_WAIT = 22_000_000,
  parameter int FRAME_W   = 16,
  parameter int TEMP_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              done_o,
  output logic [TEMP_W-1:0] temp_o,
  output logic              open_o,
  output logic              err_o,
  output logic              valid_o
);
  localparam int BW = $clog2(FRAME_W + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  tcr_state_e         state_q, state_d;
  logic               sclk_q, sclk_d;
  logic               cs_n_q, cs_n_d;
  logic               pend_q, pend_d;
  logic               done_q, done_d;
  logic [BW-1:0]      bit_q, bit_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [FRAME_W-1:0] frame_next;
  tcr_result_t        res_q, res_d, res_dec;
  logic               run, tick, hold_load, hold_done;

  assign run        = (state_q != ST_IDLE);
  assign frame_next = {shreg_q[FRAME_W-2:0], sdo_i};

  tcr_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  tcr_holdoff #(.CONV_WAIT(CONV_WAIT)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .expired(hold_done)
  );

  tcr_decode #(.FRAME_W(FRAME_W), .TEMP_W(TEMP_W)) u_dec (
    .frame(frame_next), .res(res_dec)
  );

  always_comb begin
    state_d   = state_q;
    sclk_d    = sclk_q;
    cs_n_d    = cs_n_q;
    bit_d     = bit_q;
    shreg_d   = shreg_q;
    res_d     = res_q;
    done_d    = 1'b0;
    hold_load = 1'b0;
    pend_d    = pend_q | start_i;
    case (state_q)
      ST_IDLE: begin
        if (pend_q && hold_done) begin
          state_d = ST_SETUP;
          cs_n_d  = 1'b0;
          pend_d  = 1'b0;
        end
      end
      ST_SETUP: begin
        if (tick) begin
          sclk_d  = 1'b1;
          bit_d   = '0;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (sclk_q) begin
            sclk_d  = 1'b0;
            shreg_d = frame_next;
            if (bit_q == LAST_BIT) begin
              cs_n_d    = 1'b1;
              done_d    = 1'b1;
              res_d     = res_dec;
              hold_load = 1'b1;
              state_d   = ST_IDLE;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            sclk_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= '0;
      shreg_q <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      res_q   <= res_d;
    end
  end

  assign cs_n_o  = cs_n_q;
  assign sclk_o  = sclk_q;
  assign done_o  = done_q;
  assign temp_o  = res_q.temp;
  assign open_o  = res_q.open_in;
  assign err_o   = res_q.err;
  assign valid_o = res_q.valid;
endmodule

// File: rtl/tcr_checker.sv
module tcr_checker #(
  parameter int CONV_WAIT = 22_000_000,
  parameter int TEMP_W    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic              done_o,
  input logic [TEMP_W-1:0] temp_o,
  input logic              open_o,
  input logic              err_o,
  input logic              valid_o
);
  logic        sclk_prev_q, cs_prev_q, seen_q;
  logic [4:0]  rises_q;
  logic [31:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cs_prev_q   <= 1'b1;
      seen_q      <= 1'b0;
      rises_q     <= '0;
      gap_q       <= '0;
    end else begin
      sclk_prev_q <= sclk_o;
      cs_prev_q   <= cs_n_o;
      if (cs_n_o && !cs_prev_q) seen_q <= 1'b1;
      if (cs_n_o && !cs_prev_q)        rises_q <= '0;
      else if (sclk_o && !sclk_prev_q) rises_q <= rises_q + 1'b1;
      if (!cs_n_o)                gap_q <= '0;
      else if (gap_q != '1)       gap_q <= gap_q + 1'b1;
    end
  end

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  p_sixteen_edges_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && !cs_prev_q) |-> (rises_q == 5'd16));

  p_done_with_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && !cs_prev_q));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(temp_o) && $stable(open_o) && $stable(err_o) && $stable(valid_o)));

  p_valid_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (!open_o && !err_o));

  p_conv_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n_o) && seen_q) |-> (gap_q >= 32'(CONV_WAIT)));
endmodule

bind tc_serial_reader tcr_checker #(.CONV_WAIT(CONV_WAIT), .TEMP_W(TEMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .done_o(done_o),
  .temp_o(temp_o), .open_o(open_o), .err_o(err_o), .valid_o(valid_o)
);

// File: tb/tb_tc_serial_reader.sv
`timescale 1ns/1ps
module tb_tc_serial_reader;
  localparam int HALF = 2;
  localparam int WAITC = 100;

  logic clk, rst_n, start_i, sdo_i;
  logic cs_n_o, sclk_o, done_o, open_o, err_o, valid_o;
  logic [11:0] temp_o;

  int checks, errors, cyc, rises, t_csf, setup_gap;
  bit first_rise, finished;
  logic [15:0] cur_frame;
  int idx;

  tc_serial_reader #(.HALF_DIV(HALF), .CONV_WAIT(WAITC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdo_i(sdo_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .done_o(done_o), .temp_o(temp_o),
    .open_o(open_o), .err_o(err_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(negedge clk) cyc++;

  // converter model: first bit at chip-select fall, next bits after each falling sclk
  always @(negedge cs_n_o) begin
    idx = 15; sdo_i <= cur_frame[15];
    rises = 0; t_csf = cyc; first_rise = 1'b1;
  end
  always @(negedge sclk_o) begin
    if (!cs_n_o && idx > 0) begin
      idx--; sdo_i <= cur_frame[idx];
    end
  end
  always @(posedge sclk_o) begin
    rises++;
    if (first_rise) begin setup_gap = cyc - t_csf; first_rise = 1'b0; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit s, input logic [11:0] t,
                                     input bit op, input bit id, input bit b0);
    return {s, t, op, id, b0};
  endfunction

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    if (!done_o) chk("R3 done timeout", 0, 1);
  endtask

  task automatic check_frame(input string req, input logic [15:0] f);
    bit s = f[15], op = f[2], id = f[1];
    chk({req, " temp R4"}, temp_o, f[14:3]);
    chk({req, " open R5"}, open_o, op);
    chk({req, " err R6 R7"}, err_o, s | id);
    chk({req, " valid R9"}, valid_o, !(s | id | op));
    chk({req, " edges R3"}, rises, 16);
    chk({req, " cs high at done R3"}, cs_n_o, 1);
    chk({req, " setup R2"}, int'(setup_gap >= HALF), 1);
    @(negedge clk);
    chk({req, " done width R9"}, done_o, 0);
  endtask

  task automatic do_read(input string req, input logic [15:0] f);
    cur_frame = f;
    pulse_start();
    wait_done();
    check_frame(req, f);
  endtask

  task automatic t_reset();
    chk("R1 cs_n", cs_n_o, 1); chk("R1 sclk", sclk_o, 0);
    chk("R1 done", done_o, 0); chk("R1 valid", valid_o, 0);
    chk("R1 err", err_o, 0);   chk("R1 open", open_o, 0);
    chk("R1 temp", temp_o, 0);
  endtask

  task automatic t_hold_fields();
    logic [11:0] t = temp_o;
    logic v = valid_o;
    repeat (30) @(negedge clk);
    chk("R9 temp held", temp_o, t);
    chk("R9 valid held", valid_o, v);
  endtask

  task automatic t_bit0_ignored();
    logic [11:0] t; logic v, e, o;
    do_read("R8 bit0=0", mk(0, 12'h3C5, 0, 0, 0));
    t = temp_o; v = valid_o; e = err_o; o = open_o;
    do_read("R8 bit0=1", mk(0, 12'h3C5, 0, 0, 1));
    chk("R8 temp same", temp_o, t); chk("R8 valid same", valid_o, v);
    chk("R8 err same", err_o, e);   chk("R8 open same", open_o, o);
  endtask

  task automatic t_holdoff();
    int n = 0;
    do_read("R10 first", mk(0, 12'h111, 0, 0, 0));
    cur_frame = mk(0, 12'hABC, 0, 0, 0);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0; n = 1;
    while (cs_n_o && n < 5000) begin @(negedge clk); n++; end
    chk("R10 wait length", int'(n >= WAITC), 1);
    chk("R10 request served", cs_n_o, 0);
    wait_done();
    check_frame("R10 deferred", mk(0, 12'hABC, 0, 0, 0));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; cyc = 0; rises = 0; idx = 0;
    start_i = 1'b0; sdo_i = 1'b0; cur_frame = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    do_read("R4 normal", mk(0, 12'h5A3, 0, 0, 1));
    t_hold_fields();
    do_read("R4 max", mk(0, 12'hFFF, 0, 0, 0));
    do_read("R4 zero", mk(0, 12'h000, 0, 0, 0));
    do_read("R5 open", mk(0, 12'h2A5, 1, 0, 0));
    do_read("R6 sign", mk(1, 12'h155, 0, 0, 0));
    do_read("R7 ident", mk(0, 12'h0F0, 0, 1, 0));
    t_bit0_ignored();
    t_holdoff();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule